// File: doc/BRIEF.md
# Two-Phase Serial Register Target

This block is a serial-peripheral target that exposes eleven 32-bit registers to an external host. Every transfer is framed by the active-low select line. The level of a separate command-select input, as seen when the frame opens, decides what the frame carries. With command-select high, the frame carries one 8-bit command byte. That byte names a bank, a direction and a width. With command-select low, the frame is a data phase that moves one byte or four bytes to or from the bank the last command named.

While the command byte shifts in, the target shifts out a fault-flag byte. This lets the host see the error state on every access without a separate read. All serial pins are resynchronised into the core clock, so the host clock must be several times slower than the core clock.

On the core side, a combinational read port returns any bank. Pulse inputs set the per-channel fault bits and the hardware status flags.

Bank map: 0x00 is status, 0x01 to 0x08 are the channel configurations, 0x09 is the fault register and 0x0A is the global detection configuration.

Top module: `spi_bank_target`

## Requirements
- R1: After reset, status reads 0x0004_0002: the error-mask bit 18 is 1, the undervoltage bit 1 is 1 and every other bit is 0. All other banks read 0 and the serial output is low.
- R2: A frame opened with command-select high is a command only if it carries exactly 8 bits. Bit 7 selects write (1) or read (0), bits 6:5 are ignored, bits 4:1 give the bank, and bit 0 selects byte mode (1) or full mode (0). A command frame of any other length latches nothing and counts as a communication error.
- R3: Transfers use clock mode 0, most significant bit first. The target samples on the rising edge and changes its output after the falling edge. In full mode a data phase of 32 bits writes or reads the whole bank.
- R4: In byte mode a data phase of 8 bits moves only bits 31:24. A byte write leaves bits 23:0 unchanged.
- R5: During a command frame the target shifts out status bits 7:0. While the communication-error flag (status bit 2) is set, it shifts out 0x04 instead.
- R6: Status bits 7:1 are read-only. Status bit 0 (global enable) and bits 31:8 are writable.
- R7: A completed status read clears the undervoltage flag, status bit 1.
- R8: These events are communication errors:
  - a bank above 0x0A;
  - a data phase whose bit count differs from the selected width;
  - a data phase with no valid command latched.

  A communication error sets status bit 2 only while mask bit 18 is 0. It never changes any bank. A completed status read clears bit 2.
- R9: Serial writes to bank 0x09 are ignored. A pulse on fault_set[i] sets fault bit i. A completed serial read of bank 0x09 clears the bank, and a set in the same cycle wins.
- R10: core_rdata shows the bank selected by core_addr in the same cycle. The read has no clearing side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| cmd_sel | input | 1 | High: command frame; low: data frame |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| core_addr | input | 4 | Core read bank address |
| core_rdata | output | REG_W | Core read data |
| hw_flag | input | 5 | Pulses that set status flags 7:3 |
| fault_set | input | REG_W | Pulses that set fault register bits |

## Verification
The bench builds the block with its defaults: REG_W = 32, NUM_CFG = 8 (eleven banks, the highest at 0x0A) and SYNC_STAGES = 2. It drives the serial clock at one sixteenth of the core clock. With these values, both the last valid bank 0x0A and the first invalid bank code are within reach. A 7-bit command and a 16-bit data phase exercise the length checks against both widths. The eight channel banks let byte and full writes to adjacent banks show that neither disturbs the other.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;
   localparam int CMD_W        = 8;
   localparam int CMD_WR_BIT   = 7;
   localparam int CMD_BANK_LSB = 1;
   localparam int CMD_BYTE_BIT = 0;
   localparam int BANK_W       = 4;
   localparam int MASK_BIT     = 18;
   localparam logic [7:0] COMERR_BYTE = 8'h04;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
   parameter int REG_W = 32,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_s,
   input  logic             csn_s,
   input  logic             mosi_s,
   input  logic             load_en,
   input  logic [REG_W-1:0] load_val,
   output logic             frame_start,
   output logic             frame_end,
   output logic             tx_shift,
   output logic [REG_W-1:0] rx_q,
   output logic [CNT_W-1:0] bit_cnt,
   output logic             miso
);
   logic sclk_d, csn_d, rise;
   logic [REG_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         csn_d  <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         csn_d  <= csn_s;
      end
   end

   assign frame_start = csn_d & ~csn_s;
   assign frame_end   = ~csn_d & csn_s;
   assign rise        = ~sclk_d & sclk_s & ~csn_s;
   assign tx_shift    = sclk_d & ~sclk_s & ~csn_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q    <= '0;
         bit_cnt <= '0;
      end else if (frame_start) begin
         rx_q    <= '0;
         bit_cnt <= '0;
      end else if (rise) begin
         rx_q <= {rx_q[REG_W-2:0], mosi_s};
         if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_q <= '0;
      else if (load_en)  tx_q <= load_val;
      else if (tx_shift) tx_q <= {tx_q[REG_W-2:0], 1'b0};
   end

   assign miso = tx_q[REG_W-1];
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
   import spi_bank_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int NUM_CFG = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_byte,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   input  logic              com_err,
   input  logic [4:0]        hw_flag,
   input  logic [REG_W-1:0]  fault_set,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [REG_W-1:0]  rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [REG_W-1:0]  rd_data_b,
   output logic [7:0]        fault_byte,
   output logic              uv_q,
   output logic              comerr_q,
   output logic              mask_q,
   output logic [REG_W-1:0]  fault_q
);
   localparam int NUM_REGS = NUM_CFG + 3;
   localparam logic [ADDR_W-1:0] FAULT_ADDR = ADDR_W'(NUM_CFG + 1);
   localparam logic [ADDR_W-1:0] DPM_ADDR   = ADDR_W'(NUM_CFG + 2);

   logic [REG_W-1:8] ctrl_hi;
   logic [7:3]       flags_q;
   logic             active_q;
   logic [REG_W-1:0] cfg_q [NUM_CFG];
   logic [REG_W-1:0] dpm_q;
   logic [REG_W-1:0] status, stat_new;
   logic [REG_W-1:0] all_regs [NUM_REGS];
   logic             stat_wr, stat_clr, fault_clr;

   function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old_v,
                                              input logic [REG_W-1:0] new_v,
                                              input logic             top_only);
      return top_only ? {new_v[7:0], old_v[REG_W-9:0]} : new_v;
   endfunction

   assign status    = {ctrl_hi, flags_q, comerr_q, uv_q, active_q};
   assign mask_q    = ctrl_hi[MASK_BIT];
   assign stat_wr   = wr_en && (wr_addr == '0);
   assign stat_clr  = clr_en && (clr_addr == '0);
   assign fault_clr = clr_en && (clr_addr == FAULT_ADDR);
   assign stat_new  = merge(status, wr_data, wr_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_hi           <= '0;
         ctrl_hi[MASK_BIT] <= 1'b1;
         flags_q           <= '0;
         comerr_q          <= 1'b0;
         uv_q              <= 1'b1;
         active_q          <= 1'b0;
         dpm_q             <= '0;
         fault_q           <= '0;
         for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
      end else begin
         if (stat_wr) begin
            ctrl_hi  <= stat_new[REG_W-1:8];
            active_q <= stat_new[0];
         end
         flags_q <= (stat_clr ? 5'b0 : flags_q) | hw_flag;
         if (stat_clr) uv_q <= 1'b0;
         if (com_err && !mask_q) comerr_q <= 1'b1;
         else if (stat_clr)      comerr_q <= 1'b0;
         for (int i = 0; i < NUM_CFG; i++) begin
            if (wr_en && wr_addr == ADDR_W'(i + 1))
               cfg_q[i] <= merge(cfg_q[i], wr_data, wr_byte);
         end
         if (wr_en && wr_addr == DPM_ADDR) dpm_q <= merge(dpm_q, wr_data, wr_byte);
         fault_q <= (fault_clr ? '0 : fault_q) | fault_set;
      end
   end

   always_comb begin
      all_regs[0] = status;
      for (int i = 0; i < NUM_CFG; i++) all_regs[i+1] = cfg_q[i];
      all_regs[NUM_CFG+1] = fault_q;
      all_regs[NUM_CFG+2] = dpm_q;
      rd_data_a = '0;
      rd_data_b = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr_a == ADDR_W'(i)) rd_data_a = all_regs[i];
         if (rd_addr_b == ADDR_W'(i)) rd_data_b = all_regs[i];
      end
   end

   assign fault_byte = comerr_q ? COMERR_BYTE : status[7:0];
endmodule

// File: rtl/spi_bank_target.sv
module spi_bank_target
   import spi_bank_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int NUM_CFG = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              cmd_sel,
   input  logic              mosi,
   output logic              miso,
   input  logic [BANK_W-1:0] core_addr,
   output logic [REG_W-1:0]  core_rdata,
   input  logic [4:0]        hw_flag,
   input  logic [REG_W-1:0]  fault_set
);
   localparam int CNT_W    = $clog2(REG_W + 1) + 1;
   localparam int MAX_BANK = NUM_CFG + 2;

   if (REG_W < 24 || (REG_W % 8) != 0) begin : g_bad_width
      $error("spi_bank_target: REG_W must be a multiple of 8 and at least 24");
   end
   if (MAX_BANK > (1 << BANK_W) - 1) begin : g_bad_banks
      $error("spi_bank_target: NUM_CFG leaves no room in the bank field");
   end

   logic sclk_s, csn_s, cmdsel_s, mosi_s;
   logic frame_start, frame_end, tx_shift;
   logic [REG_W-1:0] rx_q, load_val, rd_data_a;
   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       fault_byte;
   logic             uv_q, comerr_q, mask_q;
   logic [REG_W-1:0] fault_q;

   logic              cmd_phase_q, cmd_valid_q, cmd_wr_q, cmd_byte_q;
   logic [BANK_W-1:0] cmd_bank_q;
   logic [BANK_W-1:0] bank_in;
   logic              cmd_ok, data_ok, wr_en, clr_en, com_err;
   logic [CNT_W-1:0]  exp_cnt;

   spi_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({sclk, cs_n, cmd_sel, mosi}),
      .dout({sclk_s, csn_s, cmdsel_s, mosi_s})
   );

   spi_frame_shifter #(.REG_W(REG_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
      .load_en(frame_start), .load_val(load_val),
      .frame_start(frame_start), .frame_end(frame_end), .tx_shift(tx_shift),
      .rx_q(rx_q), .bit_cnt(bit_cnt), .miso(miso)
   );

   assign bank_in = rx_q[CMD_BANK_LSB +: BANK_W];
   assign cmd_ok  = (bit_cnt == CNT_W'(CMD_W)) && (bank_in <= BANK_W'(MAX_BANK));
   assign exp_cnt = cmd_byte_q ? CNT_W'(8) : CNT_W'(REG_W);
   assign data_ok = cmd_valid_q && (bit_cnt == exp_cnt);
   assign wr_en   = frame_end && !cmd_phase_q && data_ok && cmd_wr_q;
   assign clr_en  = frame_end && !cmd_phase_q && data_ok && !cmd_wr_q;
   assign com_err = frame_end && (cmd_phase_q ? !cmd_ok : !data_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_phase_q <= 1'b0;
         cmd_valid_q <= 1'b0;
         cmd_wr_q    <= 1'b0;
         cmd_byte_q  <= 1'b0;
         cmd_bank_q  <= '0;
      end else begin
         if (frame_start) cmd_phase_q <= cmdsel_s;
         if (frame_end && cmd_phase_q) begin
            cmd_valid_q <= cmd_ok;
            if (cmd_ok) begin
               cmd_wr_q   <= rx_q[CMD_WR_BIT];
               cmd_byte_q <= rx_q[CMD_BYTE_BIT];
               cmd_bank_q <= bank_in;
            end
         end
      end
   end

   always_comb begin
      if (cmdsel_s)
         load_val = {fault_byte, {(REG_W-8){1'b0}}};
      else if (cmd_valid_q && !cmd_wr_q)
         load_val = cmd_byte_q ? {rd_data_a[REG_W-1 -: 8], {(REG_W-8){1'b0}}} : rd_data_a;
      else
         load_val = '0;
   end

   spi_reg_file #(.REG_W(REG_W), .NUM_CFG(NUM_CFG), .ADDR_W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_byte(cmd_byte_q), .wr_addr(cmd_bank_q), .wr_data(rx_q),
      .clr_en(clr_en), .clr_addr(cmd_bank_q), .com_err(com_err),
      .hw_flag(hw_flag), .fault_set(fault_set),
      .rd_addr_a(cmd_bank_q), .rd_data_a(rd_data_a),
      .rd_addr_b(core_addr), .rd_data_b(core_rdata),
      .fault_byte(fault_byte), .uv_q(uv_q), .comerr_q(comerr_q),
      .mask_q(mask_q), .fault_q(fault_q)
   );
endmodule

// File: rtl/spi_bank_chk.sv
module spi_bank_chk #(
   parameter int REG_W = 32,
   parameter int NUM_CFG = 8,
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             miso,
   input logic             tx_load,
   input logic             tx_shift,
   input logic             wr_en,
   input logic             wr_byte,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             clr_en,
   input logic [3:0]       clr_addr,
   input logic             com_err,
   input logic             mask_q,
   input logic             comerr_q,
   input logic             uv_q,
   input logic [REG_W-1:0] fault_q,
   input logic [REG_W-1:0] fault_set
);
   logic stat_clr, fault_clr;
   assign stat_clr  = clr_en && (clr_addr == 4'd0);
   assign fault_clr = clr_en && (clr_addr == 4'(NUM_CFG + 1));

   // R3: output moves only on a frame load or a falling serial edge
   p_miso_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_load && !tx_shift) |=> $stable(miso));

   // R8: a committed write always had the exact bit count
   p_write_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (bit_cnt == (wr_byte ? CNT_W'(8) : CNT_W'(REG_W))));

   p_comerr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (com_err && !mask_q) |=> comerr_q);

   p_comerr_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && !stat_clr) |=> (comerr_q == $past(comerr_q)));

   // R7: completed status read drops the undervoltage flag
   p_uv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr |=> !uv_q);

   // R9: fault bits are set by pulses and otherwise only cleared by a read
   p_fault_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_set != '0) |=> ((fault_q & $past(fault_set)) == $past(fault_set)));

   p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((fault_set == '0) && !fault_clr) |=> $stable(fault_q));
endmodule

bind spi_bank_target spi_bank_chk #(.REG_W(REG_W), .NUM_CFG(NUM_CFG), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .miso(miso), .tx_load(frame_start), .tx_shift(tx_shift),
   .wr_en(wr_en), .wr_byte(cmd_byte_q), .bit_cnt(bit_cnt), .clr_en(clr_en),
   .clr_addr(cmd_bank_q), .com_err(com_err), .mask_q(mask_q), .comerr_q(comerr_q),
   .uv_q(uv_q), .fault_q(fault_q), .fault_set(fault_set)
);

// File: tb/spi_bank_target_bench.sv
module spi_bank_target_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, cmd_sel = 1'b0, mosi = 1'b0;
   logic miso;
   logic [3:0]  core_addr = 4'd0;
   logic [31:0] core_rdata;
   logic [4:0]  hw_flag = 5'd0;
   logic [31:0] fault_set = 32'd0;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spi_bank_target u_spi_bank_target (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .cmd_sel(cmd_sel),
      .mosi(mosi), .miso(miso), .core_addr(core_addr), .core_rdata(core_rdata),
      .hw_flag(hw_flag), .fault_set(fault_set)
   );

   // bank, byte mode, write data, expected full read-back
   localparam logic [68:0] VEC [6] = '{
      {4'd1,  1'b0, 32'hA5A5_1234, 32'hA5A5_1234},
      {4'd8,  1'b0, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
      {4'd10, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      {4'd1,  1'b1, 32'h0000_0077, 32'h77A5_1234},
      {4'd9,  1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
      {4'd4,  1'b1, 32'h0000_00C3, 32'hC300_0000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic sel, input int n, input logic [31:0] din,
                       output logic [31:0] dout);
      dout = '0;
      cmd_sel = sel;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         mosi = din[i];
         repeat (8) @(negedge clk);
         dout = {dout[30:0], miso};
         sclk = 1'b1;
         repeat (8) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (8) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic cmd(input logic wr, input logic [3:0] bank, input logic bm,
                      output logic [7:0] fb);
      logic [31:0] d;
      xfer(1'b1, 8, {24'h0, wr, 2'b00, bank, bm}, d);
      fb = d[7:0];
   endtask

   task automatic dat(input int n, input logic [31:0] din, output logic [31:0] dout);
      xfer(1'b0, n, din, dout);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0]  fb;
      logic [31:0] rd;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state at the ports
      check("R1 miso idle", {31'h0, miso}, 32'h0);
      core_addr = 4'd0; #1;
      check("R1 status reset", core_rdata, 32'h0004_0002);
      core_addr = 4'd1; #1;
      check("R1 cfg reset", core_rdata, 32'h0);

      // R5/R7: first fault byte shows undervoltage, read clears it
      cmd(1'b0, 4'd0, 1'b0, fb);
      check("R5 fault byte after reset", {24'h0, fb}, 32'h02);
      dat(32, 32'h0, rd);
      check("R1 status serial read", rd, 32'h0004_0002);
      cmd(1'b0, 4'd0, 1'b0, fb);
      check("R7 undervoltage cleared", {24'h0, fb}, 32'h00);
      dat(32, 32'h0, rd);
      check("R7 status after clear", rd, 32'h0004_0000);

      // R3/R4/R9: vector table
      for (int k = 0; k < 6; k++) begin
         logic [68:0] v;
         string tag;
         v = VEC[k];
         tag = (v[68:65] == 4'd9) ? "R9 fault write ignored" :
               (v[64] ? "R4 byte write" : "R3 full write/read");
         cmd(1'b1, v[68:65], v[64], fb);
         dat(v[64] ? 8 : 32, v[63:32], rd);
         cmd(1'b0, v[68:65], 1'b0, fb);
         dat(32, 32'h0, rd);
         check(tag, rd, v[31:0]);
      end

      // R4: byte read returns top byte only
      cmd(1'b0, 4'd1, 1'b1, fb);
      dat(8, 32'h0, rd);
      check("R4 byte read", rd, 32'h0000_0077);

      // R8: error masked at reset
      cmd(1'b0, 4'd15, 1'b0, fb);
      cmd(1'b0, 4'd0, 1'b0, fb);
      check("R8 masked error fault byte", {24'h0, fb}, 32'h00);
      dat(32, 32'h0, rd);
      check("R8 masked error status", rd, 32'h0004_0000);

      // R6: unmask, enable; read-only flags stay 0
      cmd(1'b1, 4'd0, 1'b0, fb);
      dat(32, 32'h0000_00FF, rd);
      cmd(1'b0, 4'd0, 1'b0, fb);
      check("R6 fault byte shows enable", {24'h0, fb}, 32'h01);
      dat(32, 32'h0, rd);
      check("R6 read-only flags", rd, 32'h0000_0001);

      // R8/R5: bad bank now flags the error
      cmd(1'b0, 4'd15, 1'b0, fb);
      cmd(1'b0, 4'd1, 1'b0, fb);
      check("R5 error fault byte", {24'h0, fb}, 32'h04);
      dat(32, 32'h0, rd);
      check("R8 bank1 untouched", rd, 32'h77A5_1234);

      // R8: short data phase discards the write
      cmd(1'b1, 4'd2, 1'b0, fb);
      dat(16, 32'h0000_FFFF, rd);
      cmd(1'b0, 4'd2, 1'b0, fb);
      dat(32, 32'h0, rd);
      check("R8 short write discarded", rd, 32'h0);

      cmd(1'b0, 4'd0, 1'b0, fb);
      dat(32, 32'h0, rd);
      check("R8 error bit in status", rd, 32'h0000_0005);
      cmd(1'b0, 4'd1, 1'b1, fb);
      check("R8 error cleared by status read", {24'h0, fb}, 32'h01);
      dat(8, 32'h0, rd);

      // R2: a 7-bit command is an error
      xfer(1'b1, 7, 32'h0000_0002, rd);
      cmd(1'b0, 4'd0, 1'b0, fb);
      check("R2 short command", {24'h0, fb}, 32'h04);
      dat(32, 32'h0, rd);

      // R9/R10: fault pulses, core read, clear on serial read
      @(negedge clk);
      fault_set = 32'h4000_0020;
      @(negedge clk);
      fault_set = 32'h0;
      core_addr = 4'd9; #1;
      check("R10 core read fault", core_rdata, 32'h4000_0020);
      @(negedge clk); #1;
      check("R10 core read no clear", core_rdata, 32'h4000_0020);
      cmd(1'b0, 4'd9, 1'b0, fb);
      dat(32, 32'h0, rd);
      check("R9 fault serial read", rd, 32'h4000_0020);
      #1;
      check("R9 fault cleared", core_rdata, 32'h0);
      core_addr = 4'd10; #1;
      check("R10 core read top bank", core_rdata, 32'hDEAD_BEEF);

      done = 1'b1;
      finish_run();
   end
endmodule